// File: doc/BRIEF.md
# Two-Word Burst Memory with Separate Read and Write Ports

This block is a synthesizable storage array with an independent read port and write port that share one address bus. Time runs on a single double-rate clock: the block alternates between a first half (standing for the rising edge of the main input clock) and a second half (standing for the rising edge of its complement). The block reports the half it is in on `phase_o`. The read address is taken in the first half and the write address in the second half, so one bus carries both every cycle pair.

Every access moves a fixed pair of words. A write brings its first word in the first half and its second word in the second half. Each word carries four active-low lane enables over 9-bit lanes, and a lane that is not enabled keeps its stored value. The storage is split into two half-arrays: word 0 of a pair lives in one and word 1 in the other, so one address selects a whole pair. A read returns its pair in order with a fixed latency. A valid/enable flag marks the output, and the data output is held at zero whenever the flag is low, which stands in for high impedance.

Top module: `qdr_b2_sram`

## Requirements
- R1: `rd_sel_n` is active low and is only sampled at an edge where `phase_o` is 0. A low sample starts a read of the pair at the `addr` value sampled on that same edge. A value of `rd_sel_n` seen on a `phase_o`=1 edge has no effect.
- R2: `wr_sel_n` is active low and is only sampled at an edge where `phase_o` is 0. When it is sampled high, the data, lane enables and address of that cycle pair leave the array unchanged.
- R3: The write address is the `addr` value sampled at the `phase_o`=1 edge that follows the write's select edge, so a read and a write in one cycle pair can use different addresses.
- R4: The `wdata` sampled with the select edge is stored as word 0 of the pair, and the `wdata` sampled at the next `phase_o`=1 edge is stored as word 1.
- R5: `wbyte_n[i]` (active low) qualifies `wdata[9*i+8:9*i]` for the word sampled on the same edge. A lane sampled high keeps its previous stored bits.
- R6: Word 0 of a read appears on `rdata` after the second edge that follows the select edge, which is the next `phase_o`=0 edge. Word 1 appears after the edge after that.
- R7: `rdata_en` is high for exactly the two output halves of each read and changes only at `phase_o`=0 edges. Whenever `rdata_en` is low, `rdata` is all zeros.
- R8: When the read select is sampled high, a read already in flight still delivers both words. `rdata_en` then falls after the next `phase_o`=0 edge.
- R9: A read and a write to the same address in the same cycle pair return the pair as it was stored before that write.
- R10: Reads issued in consecutive cycle pairs produce an unbroken stream of words with `rdata_en` held high.
- R11: While `rst_n` is low, and for two clocks after it rises, `rdata_en` and `rdata` are 0 and `phase_o` is 0. After that, `phase_o` alternates every clock, starting at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; alternate edges are the two halves |
| rst_n | input | 1 | Asynchronous active-low reset, released internally after two clocks |
| rd_sel_n | input | 1 | Read select, active low, sampled in the first half |
| wr_sel_n | input | 1 | Write select, active low, sampled in the first half |
| addr | input | AW | Shared pair address: read address in the first half, write address in the second |
| wdata | input | LANES*LW | Write word, sampled in both halves of a write |
| wbyte_n | input | LANES | Active-low lane enables, one per 9-bit lane of wdata |
| rdata | output | LANES*LW | Read word; zero when rdata_en is low |
| rdata_en | output | 1 | Output enable and valid flag for rdata |
| phase_o | output | 1 | 0 when the next edge is a first-half edge, 1 when it is a second-half edge |

## Verification
The bench first writes every pair. It then goes after the cases where a design can go quietly wrong. A read and a write to one address in the same cycle pair catches a design that forwards the new data (R9). Partial lane masks applied separately to each word catch a mask applied to the wrong word or the wrong lane. A deselected write with changing data checks that nothing is stored. A read followed by a deselect checks that a design neither cuts the second word short nor leaves the enable high for an extra cycle. Back-to-back reads and select values toggled during the second half expose a design that samples the selects on the wrong edge or swaps the two words of a pair.

// File: rtl/qdr_b2_pkg.sv
package qdr_b2_pkg;
  // Which of the two halves of a cycle pair the next clock edge is.
  typedef enum logic {
    HALF_K  = 1'b0,
    HALF_KN = 1'b1
  } half_e;

  localparam int unsigned BANKS = 2;
endpackage

// File: rtl/qdr_b2_timebase.sv
module qdr_b2_timebase
  import qdr_b2_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  output logic  rst_core_n,
  output half_e half
);
  logic  sync_q1, sync_q2;
  half_e half_q, half_d;

  // Reset asserts at once and releases two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q1 <= 1'b0;
      sync_q2 <= 1'b0;
    end else begin
      sync_q1 <= 1'b1;
      sync_q2 <= sync_q1;
    end
  end

  assign rst_core_n = sync_q2;

  always_comb begin
    half_d = (half_q == HALF_K) ? HALF_KN : HALF_K;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) half_q <= HALF_K;
    else             half_q <= half_d;
  end

  assign half = half_q;
endmodule

// File: rtl/qdr_b2_bank.sv
module qdr_b2_bank #(
  parameter int unsigned AW    = 6,
  parameter int unsigned LANES = 4,
  parameter int unsigned LW    = 9
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [LANES*LW-1:0]    wdata,
  input  logic [LANES-1:0]       wlane,
  input  logic                   re,
  input  logic [AW-1:0]          raddr,
  output logic [LANES*LW-1:0]    rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    logic [LW-1:0] rd_q;
    logic          lane_we;

    assign lane_we = we & wlane[g];

    always_ff @(posedge clk) begin
      if (lane_we) mem[waddr] <= wdata[g*LW +: LW];
    end

    // Registered read; a write on the same edge is not seen.
    always_ff @(posedge clk) begin
      if (re) rd_q <= mem[raddr];
    end

    assign rdata[g*LW +: LW] = rd_q;
  end
endmodule

// File: rtl/qdr_b2_wcap.sv
module qdr_b2_wcap
  import qdr_b2_pkg::*;
#(
  parameter int unsigned AW    = 6,
  parameter int unsigned LANES = 4,
  parameter int unsigned LW    = 9
) (
  input  logic                clk,
  input  logic                rst_core_n,
  input  half_e               half,
  input  logic                wr_sel_n,
  input  logic [AW-1:0]       addr,
  input  logic [LANES*LW-1:0] wdata,
  input  logic [LANES-1:0]    wbyte_n,
  output logic                we,
  output logic [AW-1:0]       waddr,
  output logic [LANES*LW-1:0] wd0,
  output logic [LANES*LW-1:0] wd1,
  output logic [LANES-1:0]    wl0,
  output logic [LANES-1:0]    wl1
);
  logic                pend_q, pend_d;
  logic [LANES*LW-1:0] d0_q, d0_d;
  logic [LANES-1:0]    l0_q, l0_d;
  logic                first_en, cap_en;

  assign first_en = (half == HALF_K);
  assign cap_en   = first_en & ~wr_sel_n;

  always_comb begin
    pend_d = pend_q;
    d0_d   = d0_q;
    l0_d   = l0_q;
    if (first_en) pend_d = ~wr_sel_n;
    if (cap_en) begin
      d0_d = wdata;
      l0_d = ~wbyte_n;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) pend_q <= 1'b0;
    else             pend_q <= pend_d;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      d0_q <= d0_d;
      l0_q <= l0_d;
    end
  end

  // Commit both words on the second-half edge, using the address on the bus then.
  assign we    = pend_q & (half == HALF_KN);
  assign waddr = addr;
  assign wd0   = d0_q;
  assign wl0   = l0_q;
  assign wd1   = wdata;
  assign wl1   = ~wbyte_n;
endmodule

// File: rtl/qdr_b2_rpipe.sv
module qdr_b2_rpipe
  import qdr_b2_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 36
) (
  input  logic          clk,
  input  logic          rst_core_n,
  input  half_e         half,
  input  logic          rd_sel_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] bank0_q,
  input  logic [DW-1:0] bank1_q,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          rdata_en
);
  logic          rpend_q, rpend_d;
  logic [AW-1:0] raddr_q, raddr_d;
  logic          hold_q, hold_d;
  logic          oe_q, oe_d;
  logic [DW-1:0] dq_q, dq_d;
  logic          first_en;

  assign first_en = (half == HALF_K);

  always_comb begin
    rpend_d = rpend_q;
    raddr_d = raddr_q;
    hold_d  = hold_q;
    oe_d    = oe_q;
    dq_d    = dq_q;
    if (first_en) begin
      rpend_d = ~rd_sel_n;
      if (!rd_sel_n) raddr_d = addr;
      oe_d = hold_q;
      dq_d = hold_q ? bank0_q : '0;
    end else begin
      hold_d = rpend_q;
      dq_d   = oe_q ? bank1_q : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rpend_q <= 1'b0;
      hold_q  <= 1'b0;
      oe_q    <= 1'b0;
      dq_q    <= '0;
    end else begin
      rpend_q <= rpend_d;
      hold_q  <= hold_d;
      oe_q    <= oe_d;
      dq_q    <= dq_d;
    end
  end

  always_ff @(posedge clk) begin
    if (first_en) raddr_q <= raddr_d;
  end

  assign re       = rpend_q & ~first_en;
  assign raddr    = raddr_q;
  assign rdata    = dq_q;
  assign rdata_en = oe_q;
endmodule

// File: rtl/qdr_b2_sram.sv
module qdr_b2_sram
  import qdr_b2_pkg::*;
#(
  parameter int unsigned AW    = 6,
  parameter int unsigned LANES = 4,
  parameter int unsigned LW    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_sel_n,
  input  logic                wr_sel_n,
  input  logic [AW-1:0]       addr,
  input  logic [LANES*LW-1:0] wdata,
  input  logic [LANES-1:0]    wbyte_n,
  output logic [LANES*LW-1:0] rdata,
  output logic                rdata_en,
  output logic                phase_o
);
  localparam int unsigned DW = LANES * LW;

  logic          rst_core_n;
  half_e         half;
  logic          we, re;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] wd   [BANKS];
  logic [LANES-1:0] wl [BANKS];
  logic [DW-1:0] bq   [BANKS];

  qdr_b2_timebase tb_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n),
    .half       (half)
  );

  qdr_b2_wcap #(.AW(AW), .LANES(LANES), .LW(LW)) wcap_i (
    .clk        (clk),
    .rst_core_n (rst_core_n),
    .half       (half),
    .wr_sel_n   (wr_sel_n),
    .addr       (addr),
    .wdata      (wdata),
    .wbyte_n    (wbyte_n),
    .we         (we),
    .waddr      (waddr),
    .wd0        (wd[0]),
    .wd1        (wd[1]),
    .wl0        (wl[0]),
    .wl1        (wl[1])
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    qdr_b2_bank #(.AW(AW), .LANES(LANES), .LW(LW)) bank_i (
      .clk   (clk),
      .we    (we),
      .waddr (waddr),
      .wdata (wd[b]),
      .wlane (wl[b]),
      .re    (re),
      .raddr (raddr),
      .rdata (bq[b])
    );
  end

  qdr_b2_rpipe #(.AW(AW), .DW(DW)) rpipe_i (
    .clk        (clk),
    .rst_core_n (rst_core_n),
    .half       (half),
    .rd_sel_n   (rd_sel_n),
    .addr       (addr),
    .bank0_q    (bq[0]),
    .bank1_q    (bq[1]),
    .re         (re),
    .raddr      (raddr),
    .rdata      (rdata),
    .rdata_en   (rdata_en)
  );

  assign phase_o = (half == HALF_KN);
endmodule

// File: rtl/qdr_b2_sram_chk.sv
module qdr_b2_sram_chk #(
  parameter int unsigned DW = 36
) (
  input logic          clk,
  input logic          rst_core_n,
  input logic          phase_o,
  input logic          rd_sel_n,
  input logic          rdata_en,
  input logic [DW-1:0] rdata
);
  AST_EN_STABLE_SECOND: assert property (@(posedge clk) disable iff (!rst_core_n)
    phase_o |=> $stable(rdata_en)); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_core_n)
    !rdata_en |-> (rdata == '0)); // R7
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!phase_o && !rd_sel_n) |=> ##2 rdata_en); // R6
  AST_DESELECT_OFF: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!phase_o && rd_sel_n) |=> ##2 !rdata_en); // R8
  AST_PHASE_RISE: assert property (@(posedge clk) disable iff (!rst_core_n)
    !phase_o |=> phase_o); // R11
  AST_PHASE_FALL: assert property (@(posedge clk) disable iff (!rst_core_n)
    phase_o |=> !phase_o); // R11
endmodule

bind qdr_b2_sram qdr_b2_sram_chk #(.DW(DW)) chk_i (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .phase_o    (phase_o),
  .rd_sel_n   (rd_sel_n),
  .rdata_en   (rdata_en),
  .rdata      (rdata)
);

// File: tb/qdr_b2_sram_tb_top.sv
`timescale 1ns/1ps
module qdr_b2_sram_tb_top;
  localparam int AW = 6;
  localparam int LANES = 4;
  localparam int LW = 9;
  localparam int DW = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic clk, rst_n, rd_sel_n, wr_sel_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic [LANES-1:0] wbyte_n;
  logic rdata_en, phase_o;

  int n_chk = 0;
  int n_bad = 0;
  string cur_tag = "R11";

  logic [DW-1:0] ref0 [DEPTH];
  logic [DW-1:0] ref1 [DEPTH];
  logic          pv;
  logic [DW-1:0] p0, p1;

  qdr_b2_sram #(.AW(AW), .LANES(LANES), .LW(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .addr(addr), .wdata(wdata), .wbyte_n(wbyte_n),
    .rdata(rdata), .rdata_en(rdata_en), .phase_o(phase_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] d,
                                          input logic [LANES-1:0] ben);
    logic [DW-1:0] r = old;
    for (int i = 0; i < LANES; i++)
      if (!ben[i]) r[i*LW +: LW] = d[i*LW +: LW];
    return r;
  endfunction

  function automatic logic [DW-1:0] patt(input int a, input int k);
    return DW'(a * 36'h1234567 + k * 36'h9abcdef + 36'h5a5);
  endfunction

  // One cycle pair. Entered at a negedge whose next edge is a first-half edge.
  task automatic kcycle(input bit rd, input int ra, input bit wr, input int wa,
                        input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                        input logic [LANES-1:0] b0, input logic [LANES-1:0] b1);
    logic [DW-1:0] e0, e1;
    rd_sel_n = !rd; wr_sel_n = !wr; addr = AW'(ra); wdata = d0; wbyte_n = b0;
    e0 = ref0[ra]; e1 = ref1[ra];
    @(posedge clk); @(negedge clk);
    check({cur_tag, " en w0"}, DW'(rdata_en), DW'(pv));
    check({cur_tag, " w0"}, rdata, pv ? p0 : '0);
    // Selects toggled in the second half must have no effect (R1, R2).
    rd_sel_n = rd; wr_sel_n = wr; addr = AW'(wa); wdata = d1; wbyte_n = b1;
    @(posedge clk); @(negedge clk);
    check({cur_tag, " en w1"}, DW'(rdata_en), DW'(pv));
    check({cur_tag, " w1"}, rdata, pv ? p1 : '0);
    if (wr) begin
      ref0[wa] = merge(ref0[wa], d0, b0);
      ref1[wa] = merge(ref1[wa], d1, b1);
    end
    pv = rd; p0 = e0; p1 = e1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) kcycle(0, 0, 0, 0, '0, '0, '1, '1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; rd_sel_n = 1'b1; wr_sel_n = 1'b1; addr = '0; wdata = '0; wbyte_n = '1;
    pv = 1'b0; p0 = '0; p1 = '0;
    repeat (3) @(negedge clk);
    cur_tag = "R11";
    check("R11 reset en", DW'(rdata_en), '0);
    check("R11 reset data", rdata, '0);
    check("R11 reset phase", DW'(phase_o), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    while (phase_o !== 1'b0) @(negedge clk);

    // Fill every pair with full lanes.
    cur_tag = "R4";
    for (int a = 0; a < DEPTH; a++) begin
      ref0[a] = '0; ref1[a] = '0;
    end
    for (int a = 0; a < DEPTH; a++) kcycle(0, 0, 1, a, patt(a, 0), patt(a, 1), '0, '0);

    // Back-to-back reads of every pair.
    cur_tag = "R10";
    for (int a = 0; a < DEPTH; a++) kcycle(1, a, 0, 0, '0, '0, '1, '1);
    idle(2);

    // Lane masks, different per word.
    cur_tag = "R5";
    for (int m = 0; m < 16; m++) begin
      kcycle(0, 0, 1, m + 3, patt(m, 7), patt(m, 9), LANES'(m), LANES'(~m));
      kcycle(1, m + 3, 0, 0, '0, '0, '1, '1);
    end
    idle(1);

    // Deselected write with live data and address.
    cur_tag = "R2";
    kcycle(0, 0, 0, 10, '1, '1, '0, '0);
    kcycle(1, 10, 0, 0, '0, '0, '1, '1);
    idle(1);

    // Read and write at different addresses in one cycle pair.
    cur_tag = "R3";
    kcycle(1, 20, 1, 21, patt(99, 1), patt(99, 2), '0, '0);
    kcycle(1, 21, 0, 0, '0, '0, '1, '1);
    idle(1);

    // Same address read and write: old data first.
    cur_tag = "R9";
    kcycle(1, 30, 1, 30, patt(77, 3), patt(77, 4), '0, '0);
    kcycle(1, 30, 0, 0, '0, '0, '1, '1);
    idle(1);

    // Single read then deselect: both words, then enable drops.
    cur_tag = "R8";
    kcycle(1, 5, 0, 0, '0, '0, '1, '1);
    idle(3);

    // Read latency and sampling edge with interleaved writes.
    cur_tag = "R6";
    for (int i = 0; i < 12; i++)
      kcycle(i % 3 != 0, (i * 7) % DEPTH, i % 2 == 0, (i * 5) % DEPTH,
             patt(i, 11), patt(i, 12), LANES'(i), LANES'(i >> 1));
    cur_tag = "R1";
    kcycle(0, 1, 0, 0, '0, '0, '1, '1);
    kcycle(1, 2, 0, 0, '0, '0, '1, '1);
    cur_tag = "R7";
    idle(3);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule